// File: doc/BRIEF.md
# DMA Request Handshake Sequencer

This block is the request side of a single DMA channel that steals bus cycles one transfer unit at a time. It watches an external request line and accepts only rising edges. For each accepted edge it emits a one-clock accept strobe and then runs one transfer unit on the bus. The unit is one or more bus cycles, each framed by chip-select and closed by a bus-cycle-done input from the bus side.

When the transfer size exceeds the bus width, the unit is split into several bus cycles. Chip-select drops for one clock between them. The acknowledge output either follows chip-select, giving one pulse per bus cycle, or stays high across the whole unit, giving a single pulse. After the acknowledge ends, the block spends one blind clock before it listens to the request line again. Request edges seen while busy or blind are dropped, not queued.

Top module: `dreq_handshake_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle, and on the next clock edge chip_sel, xfer_ack and req_taken are all low.
- R2: Acceptance needs a rising edge of req_in. req_taken goes high on the third rising clock edge that samples req_in high after a low sample. A request line held high gives no further acceptance.
- R3: req_taken is high for exactly one clock. chip_sel and xfer_ack are high on the clock that follows it.
- R4: The number of bus cycles per unit is 2 raised to max(0, S - W), one chip_sel pulse each. S comes from size_code: 0 gives 0 (1 byte), 1 gives 1 (2 bytes), 2 gives 2 (4 bytes), 3 gives 4 (16 bytes), 4 gives 5 (32 bytes). W is width_code: 0, 1, 2, 3 for 8, 16, 32, 64-bit buses.
- R5: chip_sel stays high until cycle_done is sampled high. Between two bus cycles of one unit, chip_sel is low for exactly one clock.
- R6: With ack_hold low, xfer_ack equals chip_sel, which gives one acknowledge pulse per bus cycle.
- R7: With ack_hold high, xfer_ack rises with the first bus cycle and stays high until the last one ends, giving one pulse per unit.
- R8: Request edges that occur during a transfer, or in the clock right after xfer_ack falls, are discarded. A later fresh edge is accepted.
- R9: size_code, width_code and ack_hold are captured at acceptance. Changing them during a unit does not alter that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 1 | Asynchronous DMA request line, edge detected |
| size_code | input | 3 | Transfer-unit size code |
| width_code | input | 2 | Bus width code |
| ack_hold | input | 1 | 1 holds the acknowledge across the unit, 0 splits it per bus cycle |
| cycle_done | input | 1 | Bus cycle completion, sampled while chip_sel is high |
| chip_sel | output | 1 | Bus cycle frame, active high |
| xfer_ack | output | 1 | Transfer acknowledge, active high |
| req_taken | output | 1 | One-clock request-accepted strobe |

## Verification
A wrong sub-cycle counter shows at the ports within one unit as too many or too few chip_sel pulses. A wrong acknowledge mode shows as an acknowledge pulse count that does not match the number of bus cycles, or that is not one, on the first gap clock. A missing blind clock or a missing edge-only sampler shows as an extra req_taken within a few clocks of the acknowledge falling or of the request line being held. A sequencer that reads the codes after acceptance changes the pulse count of the unit that is in flight.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int SIZE_W  = 3;
  localparam int WIDTH_W = 2;
  localparam int MAX_SPLIT_LOG2 = 5;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd0;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_LONG = 3'd2;
  localparam logic [SIZE_W-1:0] SZ_16B  = 3'd3;
  localparam logic [SIZE_W-1:0] SZ_32B  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCEPT  = 3'd1,
    ST_BUS     = 3'd2,
    ST_GAP     = 3'd3,
    ST_RECOVER = 3'd4
  } seq_state_t;
endpackage

// File: rtl/dreq_edge_detect.sv
module dreq_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2: a detected rise lasts one clock
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dreq_unit_count.sv
module dreq_unit_count
  import dreq_pkg::*;
#(
  parameter int LOG_W = $clog2(MAX_SPLIT_LOG2 + 1)
) (
  input  logic [SIZE_W-1:0]  size_code,
  input  logic [WIDTH_W-1:0] width_code,
  output logic [LOG_W-1:0]   split_log2
);
  logic [LOG_W-1:0] size_l2;
  logic [LOG_W-1:0] width_l2;

  always_comb begin
    unique case (size_code)
      SZ_BYTE: size_l2 = LOG_W'(0);
      SZ_WORD: size_l2 = LOG_W'(1);
      SZ_LONG: size_l2 = LOG_W'(2);
      SZ_16B:  size_l2 = LOG_W'(4);
      SZ_32B:  size_l2 = LOG_W'(5);
      default: size_l2 = LOG_W'(0);
    endcase
    width_l2 = LOG_W'(width_code);
    if (size_l2 > width_l2) split_log2 = size_l2 - width_l2;
    else                    split_log2 = '0;
  end

  // R4: split count never exceeds the largest supported division
  always_comb begin
    assert_split_range_R4: assert (split_log2 <= LOG_W'(MAX_SPLIT_LOG2));
  end
endmodule

// File: rtl/dreq_handshake_seq.sv
module dreq_handshake_seq
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_in,
  input  logic [SIZE_W-1:0]  size_code,
  input  logic [WIDTH_W-1:0] width_code,
  input  logic               ack_hold,
  input  logic               cycle_done,
  output logic               chip_sel,
  output logic               xfer_ack,
  output logic               req_taken
);
  localparam int LOG_W = $clog2(MAX_SPLIT_LOG2 + 1);
  localparam int CNT_W = MAX_SPLIT_LOG2 + 1;

  logic             req_rise;
  logic [LOG_W-1:0] split_log2;
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] idx_q;
  logic             hold_q;
  logic             last_cycle;

  dreq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (req_in),
    .rise_o   (req_rise)
  );

  dreq_unit_count #(.LOG_W(LOG_W)) u_count (
    .size_code  (size_code),
    .width_code (width_code),
    .split_log2 (split_log2)
  );

  assign last_cycle = (idx_q == total_q - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_rise) state_d = ST_ACCEPT;
      ST_ACCEPT:  state_d = ST_BUS;
      ST_BUS:     if (cycle_done) state_d = last_cycle ? ST_RECOVER : ST_GAP;
      ST_GAP:     state_d = ST_BUS;
      ST_RECOVER: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      total_q   <= CNT_W'(1);
      idx_q     <= '0;
      hold_q    <= 1'b0;
      chip_sel  <= 1'b0;
      xfer_ack  <= 1'b0;
      req_taken <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_rise) begin
        total_q <= CNT_W'(1) << split_log2;
        hold_q  <= ack_hold;
        idx_q   <= '0;
      end else if (state_q == ST_BUS && cycle_done && !last_cycle) begin
        idx_q <= idx_q + CNT_W'(1);
      end
      chip_sel  <= (state_d == ST_BUS);
      req_taken <= (state_d == ST_ACCEPT);
      xfer_ack  <= (state_d == ST_BUS) ||
                   (state_d == ST_GAP && hold_q);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!chip_sel && !xfer_ack && !req_taken));

  assert_taken_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    req_taken |=> !req_taken);

  assert_bus_after_take_R3: assert property (@(posedge clk) disable iff (rst)
    req_taken |=> (chip_sel && xfer_ack));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    chip_sel |-> (idx_q < total_q));

  assert_cs_waits_done_R5: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && !cycle_done) |=> chip_sel);

  assert_cs_implies_ack_R6: assert property (@(posedge clk) disable iff (rst)
    chip_sel |-> xfer_ack);

  assert_split_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && xfer_ack) |-> chip_sel);

  assert_held_gap_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(chip_sel) && xfer_ack) |=> (chip_sel && xfer_ack));

  assert_blind_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_ack) |=> !req_taken);
endmodule

// File: tb/sim_dreq_handshake_seq.sv
`timescale 1ns/1ps
module sim_dreq_handshake_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_in = 1'b0;
  logic [2:0] size_code = 3'd0;
  logic [1:0] width_code = 2'd0;
  logic       ack_hold = 1'b0;
  logic       cycle_done = 1'b0;
  logic       chip_sel, xfer_ack, req_taken;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dreq_handshake_seq u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .size_code(size_code),
    .width_code(width_code), .ack_hold(ack_hold), .cycle_done(cycle_done),
    .chip_sel(chip_sel), .xfer_ack(xfer_ack), .req_taken(req_taken)
  );

  // {size, width, hold, expected bus cycles}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 7'd1},  {3'd0, 2'd3, 1'b0, 7'd1},
    {3'd1, 2'd1, 1'b0, 7'd1},  {3'd1, 2'd0, 1'b0, 7'd2},
    {3'd2, 2'd0, 1'b0, 7'd4},  {3'd2, 2'd1, 1'b1, 7'd2},
    {3'd2, 2'd2, 1'b0, 7'd1},  {3'd3, 2'd0, 1'b0, 7'd16},
    {3'd3, 2'd3, 1'b1, 7'd2},  {3'd4, 2'd0, 1'b1, 7'd32},
    {3'd4, 2'd1, 1'b0, 7'd16}, {3'd4, 2'd3, 1'b0, 7'd4},
    {3'd3, 2'd2, 1'b1, 7'd4},  {3'd1, 2'd3, 1'b1, 7'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [2:0] sz, input logic [1:0] bw,
                          input logic hd, input int exp, input int wt,
                          input bit disturb,
                          output int tk, output int csp, output int ackp,
                          output int cshi, output int gaps);
    int quiet = 0, hc = 0, dst = 0;
    logic pcs = 1'b0, pack = 1'b0;
    tk = 0; csp = 0; ackp = 0; cshi = 0; gaps = 0;
    size_code = sz; width_code = bw; ack_hold = hd; req_in = 1'b1;
    for (int it = 0; it < 800 && quiet < 6; it++) begin
      @(negedge clk);
      if (req_taken) tk++;
      if (chip_sel && !pcs) csp++;
      if (xfer_ack && !pack) ackp++;
      if (chip_sel) cshi++;
      if (!chip_sel && csp > 0 && csp < exp) gaps++;
      pcs = chip_sel; pack = xfer_ack;
      cycle_done = 1'b0;
      if (chip_sel) begin
        if (hc == wt) begin cycle_done = 1'b1; hc = 0; end
        else hc++;
      end else hc = 0;
      if (disturb && csp == 2 && dst == 0) begin
        req_in = 1'b0; dst = 1;
      end else if (dst == 1) begin
        req_in = 1'b1; size_code = 3'd0; width_code = 2'd3; ack_hold = ~hd;
        dst = 2;
      end
      if (csp >= exp && !chip_sel && !xfer_ack && !req_taken) quiet++;
      else quiet = 0;
    end
    req_in = 1'b0; cycle_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int tk, csp, ackp, cshi, gaps, cnt;
    repeat (3) @(negedge clk);
    check("R1 reset chip_sel", chip_sel, 0);
    check("R1 reset xfer_ack", xfer_ack, 0);
    check("R1 reset req_taken", req_taken, 0);
    rst = 1'b0;
    @(negedge clk);

    // table-driven units
    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      int n, h;
      e = VEC[v]; n = int'(e[6:0]); h = int'(e[7]);
      run_xfer(e[12:10], e[9:8], e[7], n, 0, 1'b0, tk, csp, ackp, cshi, gaps);
      check($sformatf("R2 vec%0d accept count", v), tk, 1);
      check($sformatf("R4 vec%0d bus cycles", v), csp, n);
      check($sformatf("R5 vec%0d gap clocks", v), gaps, n - 1);
      if (h == 1) check($sformatf("R7 vec%0d held ack pulses", v), ackp, 1);
      else        check($sformatf("R6 vec%0d split ack pulses", v), ackp, n);
    end

    // R5: wait states keep chip_sel high
    run_xfer(3'd2, 2'd1, 1'b0, 2, 3, 1'b0, tk, csp, ackp, cshi, gaps);
    check("R5 cs high clocks with wait states", cshi, 8);
    check("R6 split ack with wait states", ackp, 2);

    // R8/R9: request toggle and code change in mid unit
    run_xfer(3'd3, 2'd0, 1'b0, 16, 0, 1'b1, tk, csp, ackp, cshi, gaps);
    check("R8 no acceptance during transfer", tk, 1);
    check("R9 codes frozen: bus cycles", csp, 16);
    check("R9 hold frozen: ack pulses", ackp, 16);

    // R2/R3/R8: exact latency, and an edge landing in the blind clock
    @(negedge clk); req_in = 1'b1; size_code = 3'd0; width_code = 2'd0;
    ack_hold = 1'b0;
    @(negedge clk);
    check("R2 no accept after one edge", req_taken, 0);
    @(negedge clk); req_in = 1'b0;
    check("R2 no accept after two edges", req_taken, 0);
    @(negedge clk); req_in = 1'b1;
    check("R2 accept on third edge", req_taken, 1);
    @(negedge clk);
    check("R3 strobe one clock", req_taken, 0);
    check("R3 cs follows strobe", chip_sel, 1);
    check("R3 ack follows strobe", xfer_ack, 1);
    cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
    check("R4 single byte ends", chip_sel, 0);
    cnt = 0;
    repeat (8) begin @(negedge clk); if (req_taken) cnt++; end
    check("R8 edge in blind clock dropped", cnt, 0);
    req_in = 1'b0;
    repeat (2) @(negedge clk);
    req_in = 1'b1;
    cnt = 0;
    repeat (4) begin @(negedge clk); if (req_taken) cnt++;
      if (chip_sel) cycle_done = 1'b1; else cycle_done = 1'b0; end
    check("R8 later fresh edge accepted", cnt, 1);
    cycle_done = 1'b0; req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset in mid unit
    size_code = 3'd4; width_code = 2'd0; ack_hold = 1'b1; req_in = 1'b1;
    cnt = 0;
    while (!chip_sel && cnt < 20) begin @(negedge clk); cnt++; end
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset chip_sel", chip_sel, 0);
    check("R1 mid reset xfer_ack", xfer_ack, 0);
    check("R1 mid reset req_taken", req_taken, 0);
    rst = 1'b0; req_in = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule